// File: doc/BRIEF.md
# Control-Transfer Fetch Alignment Checker

This block sits in the execute stage of a 32-bit RISC-V style core. It handles jumps, conditional branches and machine-mode trap returns. For each one it computes the next fetch address and decides whether the transfer must raise an instruction-address-misaligned exception.

The alignment rule depends on a compressed-instruction enable bit that the block holds itself. While that bit is set, 2-byte-aligned targets are legal. While it is clear, only 4-byte-aligned targets are legal.

The block drives four kinds of output in the same cycle as the instruction:
- a redirect request and its target,
- a trap request with cause, exception PC and bad-address value,
- a signal that vetoes the link-register write of a trapping jump,
- the current state of the enable bit.

Writes to the enable bit arrive as two operation codes, one that clears it and one that sets it. A clear is refused when the following instruction would sit on a 2-byte boundary.

Top module: `xfer_align_unit`

## Requirements
- R1: After reset, c_enabled_o is 1 and trap_req_o, redirect_valid_o and link_suppress_o are 0.
- R2: For op_i = 2 (register jump), the target is rs1_i + imm_i with bit 0 forced to 0. For op_i = 1 (direct jump) and op_i = 3 (branch), the target is pc_i + imm_i with bit 0 forced to 0. Bit 0 of a target therefore never causes a trap.
- R3: With c_enabled_o = 0, a taken transfer whose target has bit 1 set raises trap_req_o with trap_cause_o = 0, and redirect_valid_o stays 0. A transfer is taken when op_i is 1 or 2, or when op_i is 3 with br_taken_i = 1.
- R4: With c_enabled_o = 1, every taken transfer drives redirect_valid_o = 1 with redirect_pc_o equal to the target, and trap_req_o = 0. The same holds with c_enabled_o = 0 when target bit 1 is 0.
- R5: A branch (op_i = 3) with br_taken_i = 0 never raises trap_req_o and never redirects, whatever its target and enable state.
- R6: link_suppress_o is 1 exactly when a jump (op_i = 1 or 2) traps.
- R7: On a trap, trap_epc_o equals pc_i of the transfer and trap_tval_o equals the misaligned target. Both are 0 when no trap is raised.
- R8: A clear request (op_i = 5) drops c_enabled_o to 0 at the next clock only if bit 1 of pc_i + 4 is 0. Otherwise c_enabled_o stays 1.
- R9: A machine return (op_i = 4) redirects to mepc_i with bit 1 forced to 0 while c_enabled_o = 0, and to mepc_i unchanged while c_enabled_o = 1.
- R10: A set request (op_i = 6) raises c_enabled_o to 1 at the next clock.
- R11: trap_req_o is asserted only while valid_i = 1, and lasts one cycle per offending instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction is present in execute |
| op_i | input | 3 | Operation: 0 none, 1 direct jump, 2 register jump, 3 branch, 4 machine return, 5 clear compressed enable, 6 set compressed enable |
| pc_i | input | 32 | Address of the instruction |
| rs1_i | input | 32 | Base register value for a register jump |
| imm_i | input | 32 | Sign-extended offset |
| br_taken_i | input | 1 | Branch condition result |
| mepc_i | input | 32 | Saved exception PC used by the machine return |
| redirect_valid_o | output | 1 | Fetch must continue at redirect_pc_o |
| redirect_pc_o | output | 32 | Corrected next fetch address |
| trap_req_o | output | 1 | Misaligned-fetch trap request |
| trap_cause_o | output | 4 | Exception cause, always 0 |
| trap_epc_o | output | 32 | Address of the trapping instruction |
| trap_tval_o | output | 32 | Misaligned target reported with the trap |
| link_suppress_o | output | 1 | Veto of the destination-register write |
| c_enabled_o | output | 1 | Current compressed-instruction enable |

## Verification
The bench sweeps each transfer kind (direct jump, register jump, branch) over taken and not taken, all four values of target bits [1:0] and both enable states. This separates four cases:
- bit 0 stripping from bit 1 trapping,
- the enabled rule from the disabled rule,
- a not-taken branch from a taken one,
- a jump's link veto from a branch.

Machine returns are swept over all low bits of the saved PC in both enable states. This shows that masking applies only while the bit is clear and stops once it is set again. Clear requests are issued from both 4-byte-aligned and 2-byte-offset addresses to tell an accepted clear from a vetoed one.

// File: rtl/xau_pkg.sv
package xau_pkg;
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_JAL     = 3'd1,
        OP_JALR    = 3'd2,
        OP_BRANCH  = 3'd3,
        OP_MRET    = 3'd4,
        OP_C_CLEAR = 3'd5,
        OP_C_SET   = 3'd6
    } xfer_op_e;

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_MISALIGNED = '0;

    typedef struct packed {
        logic c_en;
    } ctrl_state_t;
endpackage

// File: rtl/xau_target.sv
// Target arithmetic for transfers and machine return.
module xau_target
    import xau_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_op_e          op,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   rs1,
    input  logic [XLEN-1:0]   imm,
    input  logic [XLEN-1:0]   mepc,
    input  logic              c_en,
    output logic [XLEN-1:0]   xfer_tgt,
    output logic [XLEN-1:0]   ret_tgt
);
    localparam logic [XLEN-1:0] BIT1_MASK = ~(XLEN'(2));

    logic [XLEN-1:0] sum;

    always_comb begin
        sum      = (op == OP_JALR) ? (rs1 + imm) : (pc + imm);
        // bit 0 is discarded before any alignment decision
        xfer_tgt = {sum[XLEN-1:1], 1'b0};
        // bit 1 of the saved PC is only honoured when 2-byte fetch is legal
        ret_tgt  = c_en ? mepc : (mepc & BIT1_MASK);
    end
endmodule

// File: rtl/xau_check.sv
// Taken / misaligned decision.
module xau_check
    import xau_pkg::*;
(
    input  logic     valid,
    input  xfer_op_e op,
    input  logic     br_taken,
    input  logic     c_en,
    input  logic     tgt_bit1,
    output logic     trap,
    output logic     xfer_go,
    output logic     ret_go,
    output logic     is_jump
);
    logic taken;
    logic misaligned;

    always_comb begin
        is_jump    = (op == OP_JAL) || (op == OP_JALR);
        taken      = valid && (is_jump || ((op == OP_BRANCH) && br_taken));
        misaligned = !c_en && tgt_bit1;
        trap       = taken && misaligned;
        xfer_go    = taken && !misaligned;
        ret_go     = valid && (op == OP_MRET);
    end
endmodule

// File: rtl/xau_ctrl.sv
// Compressed-enable state with the clear veto.
module xau_ctrl
    import xau_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid,
    input  xfer_op_e op,
    input  logic     next_pc_bit1,
    output logic     c_en
);
    ctrl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (valid && (op == OP_C_SET)) begin
            state_d.c_en = 1'b1;
        end else if (valid && (op == OP_C_CLEAR) && !next_pc_bit1) begin
            state_d.c_en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.c_en <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign c_en = state_q.c_en;
endmodule

// File: rtl/xfer_align_unit.sv
module xfer_align_unit
    import xau_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [2:0]         op_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    rs1_i,
    input  logic [XLEN-1:0]    imm_i,
    input  logic               br_taken_i,
    input  logic [XLEN-1:0]    mepc_i,
    output logic               redirect_valid_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic               trap_req_o,
    output logic [CAUSE_W-1:0] trap_cause_o,
    output logic [XLEN-1:0]    trap_epc_o,
    output logic [XLEN-1:0]    trap_tval_o,
    output logic               link_suppress_o,
    output logic               c_enabled_o
);
    xfer_op_e        op;
    logic            c_en;
    logic [XLEN-1:0] xfer_tgt;
    logic [XLEN-1:0] ret_tgt;
    logic [XLEN-1:0] next_pc;
    logic            trap, xfer_go, ret_go, is_jump;

    assign op      = xfer_op_e'(op_i);
    assign next_pc = pc_i + XLEN'(4);

    xau_target #(.XLEN(XLEN)) i_target (
        .op(op), .pc(pc_i), .rs1(rs1_i), .imm(imm_i), .mepc(mepc_i),
        .c_en(c_en), .xfer_tgt(xfer_tgt), .ret_tgt(ret_tgt)
    );

    xau_check i_check (
        .valid(valid_i), .op(op), .br_taken(br_taken_i), .c_en(c_en),
        .tgt_bit1(xfer_tgt[1]), .trap(trap), .xfer_go(xfer_go),
        .ret_go(ret_go), .is_jump(is_jump)
    );

    xau_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .valid(valid_i), .op(op),
        .next_pc_bit1(next_pc[1]), .c_en(c_en)
    );

    always_comb begin
        redirect_valid_o = xfer_go || ret_go;
        redirect_pc_o    = ret_go ? ret_tgt : xfer_tgt;
        trap_req_o       = trap;
        trap_cause_o     = CAUSE_FETCH_MISALIGNED;
        // policy: report the misaligned target, never zero, on a trap
        trap_epc_o       = trap ? pc_i : '0;
        trap_tval_o      = trap ? xfer_tgt : '0;
        link_suppress_o  = trap && is_jump;
        c_enabled_o      = c_en;
    end
endmodule

// File: rtl/xau_checker.sv
module xau_checker
    import xau_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               valid_i,
    input logic [2:0]         op_i,
    input logic [XLEN-1:0]    pc_i,
    input logic               br_taken_i,
    input logic               redirect_valid_o,
    input logic [XLEN-1:0]    redirect_pc_o,
    input logic               trap_req_o,
    input logic [CAUSE_W-1:0] trap_cause_o,
    input logic [XLEN-1:0]    trap_epc_o,
    input logic               link_suppress_o,
    input logic               c_enabled_o
);
    assert_trap_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> valid_i);

    assert_no_trap_when_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c_enabled_o |-> !trap_req_o);

    assert_trap_blocks_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (!redirect_valid_o && trap_cause_o == '0));

    assert_not_taken_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd3 && !br_taken_i) |-> (!trap_req_o && !redirect_valid_o));

    assert_epc_is_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (trap_epc_o == pc_i));

    assert_suppress_only_on_jump_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        link_suppress_o |-> (trap_req_o && (op_i == 3'd1 || op_i == 3'd2)));

    assert_target_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid_o && op_i != 3'd4) |-> !redirect_pc_o[0]);

    assert_clear_vetoed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd5 && pc_i[1]) |=> $stable(c_enabled_o));

    assert_set_takes_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd6) |=> c_enabled_o);
endmodule

bind xfer_align_unit xau_checker #(.XLEN(XLEN)) i_xau_checker (.*);

// File: tb/test_xfer_align_unit.sv
module test_xfer_align_unit;
    import xau_pkg::*;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid_i = 1'b0;
    logic [2:0]      op_i = 3'd0;
    logic [XLEN-1:0] pc_i = '0, rs1_i = '0, imm_i = '0, mepc_i = '0;
    logic            br_taken_i = 1'b0;
    logic            redirect_valid_o, trap_req_o, link_suppress_o, c_enabled_o;
    logic [XLEN-1:0] redirect_pc_o, trap_epc_o, trap_tval_o;
    logic [CAUSE_W-1:0] trap_cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xfer_align_unit #(.XLEN(XLEN)) i_xfer_align_unit (.*);

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        valid_i = 1'b0;
        op_i = 3'd0;
    endtask

    task automatic write_c(input logic set, input logic [XLEN-1:0] at_pc);
        @(negedge clk);
        valid_i = 1'b1;
        op_i = set ? 3'd6 : 3'd5;
        pc_i = at_pc;
        idle();
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "c_enabled", XLEN'(c_enabled_o), 1);
        chk("R1", "trap", XLEN'(trap_req_o), 0);
        chk("R1", "redirect", XLEN'(redirect_valid_o), 0);
        chk("R1", "suppress", XLEN'(link_suppress_o), 0);

        for (int ce = 1; ce >= 0; ce--) begin
            write_c(ce[0], 32'h0000_0100);
            #1;
            chk(ce[0] ? "R10" : "R8", "enable state", XLEN'(c_enabled_o), XLEN'(ce[0]));
            for (int k = 1; k <= 3; k++) begin
                for (int tk = 0; tk < 2; tk++) begin
                    for (int lo = 0; lo < 4; lo++) begin
                        logic [XLEN-1:0] tgt;
                        logic taken, mis;
                        @(negedge clk);
                        valid_i = 1'b1;
                        op_i = 3'(k);
                        pc_i = 32'h0000_1000;
                        rs1_i = 32'h0000_2000;
                        imm_i = 32'h0000_0040 + 32'(lo);
                        br_taken_i = tk[0];
                        #1;
                        tgt = ((k == 2) ? rs1_i + imm_i : pc_i + imm_i) & ~32'h1;
                        taken = (k != 3) || (tk != 0);
                        mis = taken && (ce == 0) && tgt[1];
                        // R3 R5 trap decision
                        chk(k == 3 && tk == 0 ? "R5" : "R3", "trap", XLEN'(trap_req_o), XLEN'(mis));
                        // R4 redirect decision
                        chk("R4", "redirect_valid", XLEN'(redirect_valid_o), XLEN'(taken && !mis));
                        if (taken && !mis) chk("R2", "redirect_pc", redirect_pc_o, tgt);
                        chk("R6", "suppress", XLEN'(link_suppress_o), XLEN'(mis && k != 3));
                        chk("R7", "epc", trap_epc_o, mis ? pc_i : '0);
                        chk("R7", "tval", trap_tval_o, mis ? tgt : '0);
                        if (mis) chk("R3", "cause", XLEN'(trap_cause_o), 0);
                    end
                end
            end
            // R9 machine return masking
            for (int lo = 0; lo < 4; lo++) begin
                @(negedge clk);
                valid_i = 1'b1;
                op_i = 3'd4;
                mepc_i = 32'h0000_3000 + 32'(lo);
                #1;
                chk("R9", "mret redirect", XLEN'(redirect_valid_o), 1);
                chk("R9", "mret target", redirect_pc_o,
                    (ce != 0) ? mepc_i : (mepc_i & ~32'h2));
            end
            idle();
            // R11 no trap when idle
            #1;
            chk("R11", "idle trap", XLEN'(trap_req_o), 0);
        end

        // R11 misaligned target with valid low: no trap
        @(negedge clk);
        valid_i = 1'b0;
        op_i = 3'd1;
        imm_i = 32'h0000_0042;
        #1;
        chk("R11", "trap without valid", XLEN'(trap_req_o), 0);
        idle();

        // R8 clear from a 2-byte-offset address is vetoed
        write_c(1'b1, 32'h0000_0100);
        write_c(1'b0, 32'h0000_0102);
        #1;
        chk("R8", "veto keeps enable", XLEN'(c_enabled_o), 1);
        write_c(1'b0, 32'h0000_0104);
        #1;
        chk("R8", "aligned clear", XLEN'(c_enabled_o), 0);
        write_c(1'b1, 32'h0000_0106);
        #1;
        chk("R10", "set from any address", XLEN'(c_enabled_o), 1);

        // R9 unmasked again after re-enable
        @(negedge clk);
        valid_i = 1'b1;
        op_i = 3'd4;
        mepc_i = 32'h0000_4002;
        #1;
        chk("R9", "no mask once set", redirect_pc_o, 32'h0000_4002);
        idle();

        // R11 single-cycle trap pulse
        write_c(1'b0, 32'h0000_0200);
        @(negedge clk);
        valid_i = 1'b1;
        op_i = 3'd1;
        pc_i = 32'h0000_1000;
        imm_i = 32'h0000_0002;
        #1;
        chk("R11", "pulse high", XLEN'(trap_req_o), 1);
        idle();
        #1;
        chk("R11", "pulse low", XLEN'(trap_req_o), 0);

        // R1 reset restores the enable
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "enable after reset", XLEN'(c_enabled_o), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule